// File: doc/BRIEF.md
# Pin-Bank Register Block with Per-Pin Masked Writes

This block holds the control state for one bank of general-purpose pins, arranged as four ports of eight pins each. Per port it keeps three writable 8-bit registers: an ownership register (a 1 puts the pin under the control of this block), a drive-enable register and an output-value register. It also offers a read-only view of the pad levels, taken through a two-flop synchroniser. The registers are reached over a simple single-cycle memory-mapped bus. The block presents per-pin pad signals for ownership, drive enable and output value, and takes the raw pad level in.

Every writable register can be reached at two addresses. A plain write replaces all eight bits. A masked write uses the upper byte of the data as a per-pin update enable and the lower byte as the new values, so software can change one pin without first reading the register back. Pin `n` of port `p` sits at bit `8*p + n` of every pad vector.

Top module: `pinbank_regs`

## Requirements
- R1: After reset every register reads 0, so `pin_own`, `pin_oe` and `pin_out` are all 0 and every pin is a non-owned input.
- R2: Plain addresses are word offsets 4*p within a 16-byte group, with group 0x00 ownership, 0x10 drive enable, 0x20 output value and 0x30 input. A plain write to a writable group replaces all 8 bits of port p with `bus_wdata[7:0]` in the next cycle. A read returns the value in bits 7:0 and zero above.
- R3: The masked alias of each writable register is at the plain address plus 0x80. A write there sets bit n to `bus_wdata[n]` when `bus_wdata[8+n]` is 1 and leaves bit n unchanged when `bus_wdata[8+n]` is 0.
- R4: A read of a masked alias returns the current register value in bits 7:0 and zero in bits 31:8.
- R5: The input group reads `pin_in` through two flops. A pad change made before clock edge k is not visible in a read after edge k, and is visible in a read after edge k+1.
- R6: `pin_own` equals the ownership registers and `pin_out` equals the output-value registers. `pin_oe[i]` is 1 exactly when both the ownership bit and the drive-enable bit of pin i are 1.
- R7: Addresses 0x40–0x7F and 0xB0–0xFF read as zero, and writes to them change no register.
- R8: Writes to the plain input group (0x30–0x3C) are ignored. Reads there still return the synchronised pad level.
- R9: No register changes in a cycle without `bus_sel` and `bus_wr` both high, and reads have no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address (low two bits ignored) |
| bus_wdata | input | 32 | Write data; for masked writes [15:8] enable, [7:0] values |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe |
| pin_own | output | 32 | Pin is owned by this block |
| pin_oe | output | 32 | Pad drive enable |
| pin_out | output | 32 | Pad output value |
| pin_in | input | 32 | Raw pad level |

## Verification
The hardest case to reach from the ports is a masked write whose enable byte and value byte disagree on a register that already holds a mixed pattern. In that case an enable-0, value-1 pin must keep a 0, and an enable-0, value-0 pin must keep a 1. The stimulus first loads a known mixed pattern with a plain write. It then applies masked writes whose enables cover only part of the byte, while the value byte sets every bit opposite to the stored one. It checks the result through both the plain address and the alias. A second delicate point is the synchroniser latency: the pad is changed at a falling edge, and the input group is read after exactly one and then two rising edges.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    // register group selected by address bits [5:4] of the local offset
    typedef enum logic [1:0] {
        GRP_OWN = 2'd0,
        GRP_DIR = 2'd1,
        GRP_VAL = 2'd2,
        GRP_PAD = 2'd3
    } grp_e;

    // new register value for a plain or a masked write
    function automatic logic [7:0] merge_byte(input logic [7:0] old_v,
                                              input logic [7:0] new_v,
                                              input logic [7:0] en_v,
                                              input logic       masked);
        logic [7:0] res;
        if (masked) res = (old_v & ~en_v) | (new_v & en_v);
        else        res = new_v;
        return res;
    endfunction

endpackage

// File: rtl/pinbank_decode.sv
module pinbank_decode
    import pinbank_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_PORTS = 4,
    parameter int ALIAS_OFS = 'h80
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              masked,
    output grp_e              grp,
    output logic [1:0]        port
);
    localparam logic [ADDR_W-1:0] AOFS = ADDR_W'(ALIAS_OFS);

    logic [ADDR_W-1:0] loc_a;

    always_comb begin
        masked = (addr >= AOFS);
        loc_a  = masked ? (addr - AOFS) : addr;
        grp    = grp_e'(loc_a[5:4]);
        port   = loc_a[3:2];
        hit    = ((loc_a >> 6) == '0)
               && (32'(port) < NUM_PORTS)
               && !(masked && grp == GRP_PAD);
    end

endmodule

// File: rtl/pinbank_port.sv
module pinbank_port
    import pinbank_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            masked,
    input  grp_e            grp,
    input  logic [2*PINS-1:0] wdata,
    output logic [PINS-1:0] own_q,
    output logic [PINS-1:0] dir_q,
    output logic [PINS-1:0] val_q
);
    typedef struct packed {
        logic [PINS-1:0] own;
        logic [PINS-1:0] dir;
        logic [PINS-1:0] val;
    } port_st_t;

    port_st_t st_d, st_q;
    logic [PINS-1:0] w_val, w_en;

    assign w_val = wdata[PINS-1:0];
    assign w_en  = wdata[2*PINS-1:PINS];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (grp)
                GRP_OWN: st_d.own = merge_byte(st_q.own, w_val, w_en, masked);
                GRP_DIR: st_d.dir = merge_byte(st_q.dir, w_val, w_en, masked);
                GRP_VAL: st_d.val = merge_byte(st_q.val, w_val, w_en, masked);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign own_q = st_q.own;
    assign dir_q = st_q.dir;
    assign val_q = st_q.val;

    // R3
    masked_keep_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && masked && grp == GRP_VAL)
        |=> (((val_q ^ $past(val_q)) & ~$past(w_en)) == '0)
            && (((val_q ^ $past(w_val)) & $past(w_en)) == '0));

    // R3
    masked_keep_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && masked && grp == GRP_DIR)
        |=> (((dir_q ^ $past(dir_q)) & ~$past(w_en)) == '0));

    // R2
    plain_replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !masked && grp == GRP_OWN) |=> (own_q == $past(w_val)));

    // R9
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(own_q) && $stable(dir_q) && $stable(val_q)));

endmodule

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_sync
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [1:0]   age;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.s1  = pad_in;
        st_d.s2  = st_q.s1;
        if (st_q.age != 2'd2) st_d.age = st_q.age + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pad_sync = st_q.s2;

    // R5
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.age == 2'd2) |-> (pad_sync == $past(pad_in, 2)));

endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
    import pinbank_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int NUM_PORTS = 4,
    parameter int PINS      = 8,
    parameter int ALIAS_OFS = 'h80,
    localparam int NPIN     = NUM_PORTS * PINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NPIN-1:0]   pin_own,
    output logic [NPIN-1:0]   pin_oe,
    output logic [NPIN-1:0]   pin_out,
    input  logic [NPIN-1:0]   pin_in
);
    logic       dec_hit, dec_masked;
    grp_e       dec_grp;
    logic [1:0] dec_port;

    logic [PINS-1:0] own_r [NUM_PORTS];
    logic [PINS-1:0] dir_r [NUM_PORTS];
    logic [PINS-1:0] val_r [NUM_PORTS];
    logic [NPIN-1:0] pad_s;
    logic [PINS-1:0] rd_byte;
    logic            wr_any;

    pinbank_decode #(
        .ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS), .ALIAS_OFS(ALIAS_OFS)
    ) u_dec (
        .addr(bus_addr), .hit(dec_hit), .masked(dec_masked),
        .grp(dec_grp), .port(dec_port)
    );

    assign wr_any = bus_sel && bus_wr && dec_hit && (dec_grp != GRP_PAD);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic wr_p;
        assign wr_p = wr_any && (32'(dec_port) == p);

        pinbank_port #(.PINS(PINS)) u_port (
            .clk(clk), .rst_n(rst_n), .wr_en(wr_p), .masked(dec_masked),
            .grp(dec_grp), .wdata(bus_wdata[2*PINS-1:0]),
            .own_q(own_r[p]), .dir_q(dir_r[p]), .val_q(val_r[p])
        );

        assign pin_own[p*PINS +: PINS] = own_r[p];
        assign pin_out[p*PINS +: PINS] = val_r[p];
        assign pin_oe [p*PINS +: PINS] = own_r[p] & dir_r[p];
    end

    pinbank_sync #(.W(NPIN)) u_sync (
        .clk(clk), .rst_n(rst_n), .pad_in(pin_in), .pad_sync(pad_s)
    );

    always_comb begin
        rd_byte = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (32'(dec_port) == p) begin
                unique case (dec_grp)
                    GRP_OWN: rd_byte = own_r[p];
                    GRP_DIR: rd_byte = dir_r[p];
                    GRP_VAL: rd_byte = val_r[p];
                    default: rd_byte = pad_s[p*PINS +: PINS];
                endcase
            end
        end
        bus_rdata = '0;
        if (bus_sel && !bus_wr && dec_hit) bus_rdata[PINS-1:0] = rd_byte;
    end

    // R4
    alias_rd_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && dec_masked) |-> (bus_rdata[DATA_W-1:PINS] == '0));

    // R7
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !dec_hit)
        |=> ($stable(pin_own) && $stable(pin_oe) && $stable(pin_out)));

    // R8
    pad_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && dec_hit && dec_grp == GRP_PAD)
        |=> ($stable(pin_own) && $stable(pin_oe) && $stable(pin_out)));

endmodule

// File: tb/pinbank_regs_tb.sv
module pinbank_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_own, pin_oe, pin_out;
    logic [31:0] pin_in = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] m_own [4];
    logic [7:0] m_dir [4];
    logic [7:0] m_val [4];

    always #10 clk = ~clk;

    pinbank_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_own(pin_own), .pin_oe(pin_oe), .pin_out(pin_out), .pin_in(pin_in)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        #2 bus_sel = 1'b0;
    endtask

    function automatic logic [7:0] model_merge(input logic [7:0] o, input logic [15:0] d, input bit msk);
        return msk ? ((o & ~d[15:8]) | (d[7:0] & d[15:8])) : d[7:0];
    endfunction

    function automatic logic [31:0] pack(input int kind);
        logic [31:0] r;
        for (int p = 0; p < 4; p++)
            r[p*8 +: 8] = (kind == 0) ? m_own[p] : (kind == 1) ? (m_own[p] & m_dir[p]) : m_val[p];
        return r;
    endfunction

    task automatic do_reset;
        logic [31:0] d;
        for (int p = 0; p < 4; p++) begin m_own[p] = '0; m_dir[p] = '0; m_val[p] = '0; end
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 own", pin_own, 32'h0);
        check("R1 oe", pin_oe, 32'h0);
        check("R1 out", pin_out, 32'h0);
        bus_read(8'h2C, d); check("R1 read val p3", d, 32'h0);
    endtask

    task automatic test_plain;
        logic [31:0] d;
        for (int p = 0; p < 4; p++) begin
            bus_write(8'(p*4),        32'hFFFF_FF00 | 32'(8'h3C ^ 8'(p*17)));
            m_own[p] = 8'h3C ^ 8'(p*17);
            bus_write(8'(8'h10 + p*4), 32'h1234_AA00 | 32'(8'hF0 >> p));
            m_dir[p] = 8'hF0 >> p;
            bus_write(8'(8'h20 + p*4), 32'h00FF_0000 | 32'(8'h81 + 8'(p)));
            m_val[p] = 8'h81 + 8'(p);
        end
        for (int p = 0; p < 4; p++) begin
            bus_read(8'(p*4), d);        check("R2 own readback", d, {24'h0, m_own[p]});
            bus_read(8'(8'h10 + p*4), d); check("R2 dir readback", d, {24'h0, m_dir[p]});
            bus_read(8'(8'h20 + p*4), d); check("R2 val readback", d, {24'h0, m_val[p]});
        end
        check("R6 own pads", pin_own, pack(0));
        check("R6 oe pads", pin_oe, pack(1));
        check("R6 out pads", pin_out, pack(2));
    endtask

    task automatic test_masked;
        logic [31:0] d;
        // known mixed pattern, then partial-enable masked writes with inverted values
        bus_write(8'h24, 32'h0000_00A5); m_val[1] = 8'hA5;
        bus_write(8'hA4, 32'h0000_0F5A); m_val[1] = model_merge(8'hA5, 16'h0F5A, 1'b1);
        bus_read(8'h24, d); check("R3 val masked low nibble", d, {24'h0, m_val[1]});
        bus_read(8'hA4, d); check("R4 alias read", d, {24'h0, m_val[1]});
        bus_write(8'h98, 32'hFFFF_0000 | 32'h0000_8100); m_dir[2] = model_merge(m_dir[2], 16'h8100, 1'b1);
        bus_read(8'h18, d); check("R3 dir clear two bits", d, {24'h0, m_dir[2]});
        bus_write(8'h8C, 32'h0000_0000 | 32'h0000_00FF);
        bus_read(8'h0C, d); check("R3 zero enable keeps", d, {24'h0, m_own[3]});
        bus_write(8'h80, 32'h0000_FF00 | 32'h0000_0013); m_own[0] = 8'h13;
        bus_read(8'h80, d); check("R4 alias read own", d, {24'h0, m_own[0]});
        check("R6 oe after masked", pin_oe, pack(1));
        check("R6 out after masked", pin_out, pack(2));
    endtask

    task automatic test_sync;
        logic [31:0] d;
        @(negedge clk);
        pin_in = 32'hA5C3_0F96;
        @(posedge clk);
        bus_read(8'h30, d); check("R5 one edge old", d, 32'h0);
        bus_read(8'h30, d); check("R5 two edges new", d, 32'h96);
        bus_read(8'h3C, d); check("R5 port3 pads", d, 32'hA5);
        bus_write(8'h34, 32'hFFFF_FFFF);
        bus_read(8'h34, d); check("R8 pad write ignored", d, 32'h0F);
        check("R8 pads unchanged", pin_out, pack(2));
        bus_read(8'hB0, d); check("R7 alias of input reads zero", d, 32'h0);
    endtask

    task automatic test_unmapped;
        logic [31:0] d;
        bus_write(8'h40, 32'hFFFF_FFFF);
        bus_write(8'h7C, 32'hFFFF_FFFF);
        bus_write(8'hB4, 32'hFFFF_FFFF);
        bus_write(8'hC0, 32'hFFFF_FFFF);
        bus_read(8'h44, d); check("R7 read 0x44", d, 32'h0);
        bus_read(8'hF8, d); check("R7 read 0xF8", d, 32'h0);
        check("R7 own unchanged", pin_own, pack(0));
        check("R7 oe unchanged", pin_oe, pack(1));
        check("R7 out unchanged", pin_out, pack(2));
    endtask

    task automatic test_idle;
        logic [31:0] d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b1; bus_addr = 8'h20; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        check("R9 write without select", pin_out, pack(2));
        for (int i = 0; i < 3; i++) bus_read(8'h08, d);
        check("R9 reads no side effect", d, {24'h0, m_own[2]});
        check("R9 own stable", pin_own, pack(0));
    endtask

    initial begin
        do_reset();
        test_plain();
        test_masked();
        test_sync();
        test_unmapped();
        test_idle();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule